// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page table entry from memory. The caller supplies the physical base of the running process's table on `pt_base`. The walker adds the scaled virtual page number to that base and performs one read through a simple request/response memory port. It then inspects the control flags of the entry. The result is either a physical address or a two-bit fault code.

When a permitted store reaches a page whose modified flag is still clear, the walker writes the entry back with that flag set before it reports. This lets replacement software tell clean pages from dirty ones. The walker takes one translation at a time and signals its availability with `req_ready`.

Top module: `ptw_walker`

## Requirements
- R1: For each accepted request the walker issues exactly one memory read, at address `pt_base + vpn * 4`. `vpn` is `req_vaddr[31:10]` and `pt_base` is sampled when the request is accepted.
- R2: If entry bit 0 (present) is 0, the result carries fault code 1 and a physical address of 0, and no write-back occurs. This check takes precedence over all other checks.
- R3: With no fault, `rsp_paddr` equals entry bits [25:4] (the frame number) placed above the unchanged 10-bit offset `req_vaddr[9:0]`.
- R4: A store (`req_write`=1) to a present page whose entry bit 1 (writable) is 0 gives fault code 2, provided no privilege fault applies.
- R5: A user access (`req_user`=1) to a present page whose entry bit 2 (user) is 0 gives fault code 3. This code wins over code 2. A kernel access (`req_user`=0) is never refused on privilege.
- R6: A fault-free store to an entry whose bit 3 (modified) is 0 writes the entry back to the same address with bit 3 set, before the result is reported. Loads, and stores to entries already marked modified, cause no memory write.
- R7: `req_ready` is 1 only while the walker is idle. A request is accepted on a cycle where `req_valid` and `req_ready` are both 1. While busy, `req_valid` has no effect.
- R8: Each accepted request yields `rsp_valid` high for exactly one cycle.
- R9: A memory request, whether read or write-back, holds its valid, address and data stable until `mem_req_ready` is seen high. The result is the same when that acknowledgement stalls.
- R10: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Physical base address of the current page table |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user-mode access, 0 = kernel |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 write-protect, 3 privilege |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Entry value for write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Entry value read |

## Verification
The assertions assume the memory side answers each accepted read with exactly one `mem_rsp_valid` pulse, and never answers while no read is outstanding. The bench's memory model keeps to this by producing one response, one cycle after each read handshake, and nothing for writes. The assertions also assume that requesters drop `req_valid` once their request is accepted. The bench drives requests at the falling edge and deasserts them after acceptance. It also holds `req_valid` high through one busy period on purpose, to show that extra requests are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_WPROT  = 2'd2,
        FLT_PRIV   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_WBACK,
        ST_RESP
    } walk_state_e;

    // Entry flag positions; frame number starts just above them
    localparam int FLAG_PRESENT  = 0;
    localparam int FLAG_WRITABLE = 1;
    localparam int FLAG_USER     = 2;
    localparam int FLAG_DIRTY    = 3;
    localparam int FRAME_LSB     = 4;

endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc
    import ptw_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_BITS   = 10,
    parameter int PTE_W       = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PTE_W-1:0] pte,
    output logic [PA_W-1:0]  entry_addr,
    output logic [PA_W-1:0]  paddr
);
    localparam int VPN_W       = VA_W - PAGE_BITS;
    localparam int FRAME_W     = PA_W - PAGE_BITS;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [VPN_W-1:0]   vpn;
    logic [FRAME_W-1:0] frame;

    always_comb begin
        vpn        = vaddr[VA_W-1:PAGE_BITS];
        entry_addr = base + (PA_W'(vpn) << ENTRY_SHIFT);
        frame      = pte[FRAME_LSB +: FRAME_W];
        paddr      = {frame, vaddr[PAGE_BITS-1:0]};
    end

    generate
        if (FRAME_LSB + FRAME_W < PTE_W) begin : g_spare
            logic unused_spare_bits;
            assign unused_spare_bits = ^{pte[PTE_W-1:FRAME_LSB+FRAME_W], pte[FRAME_LSB-1:0]};
        end else begin : g_nospare
            logic unused_flag_bits;
            assign unused_flag_bits = ^pte[FRAME_LSB-1:0];
        end
    endgenerate

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [3:0] flags,
    input  logic       is_write,
    input  logic       is_user,
    output fault_e     fault,
    output logic       need_wb
);
    always_comb begin
        fault   = FLT_NONE;
        need_wb = 1'b0;
        if (!flags[FLAG_PRESENT]) begin
            fault = FLT_ABSENT;
        end else if (is_user && !flags[FLAG_USER]) begin
            fault = FLT_PRIV;
        end else if (is_write && !flags[FLAG_WRITABLE]) begin
            fault = FLT_WPROT;
        end else begin
            need_wb = is_write && !flags[FLAG_DIRTY];
        end
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_BITS   = 10,
    parameter int PTE_W       = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [PTE_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_rdata
);
    typedef struct packed {
        walk_state_e      st;
        logic [VA_W-1:0]  vaddr;
        logic             wr;
        logic             usr;
        logic [PA_W-1:0]  base;
        logic [PTE_W-1:0] pte;
        logic [PA_W-1:0]  paddr;
        fault_e           fault;
    } walk_ctx_t;

    walk_ctx_t        ctx_d, ctx_q;
    logic [PA_W-1:0]  entry_addr;
    logic [PA_W-1:0]  xlat_paddr;
    fault_e           chk_fault;
    logic             chk_need_wb;

    ptw_addr_calc #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
        .PTE_W(PTE_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) addr_calc_i (
        .base       (ctx_q.base),
        .vaddr      (ctx_q.vaddr),
        .pte        (mem_rsp_rdata),
        .entry_addr (entry_addr),
        .paddr      (xlat_paddr)
    );

    ptw_pte_check pte_check_i (
        .flags    (mem_rsp_rdata[3:0]),
        .is_write (ctx_q.wr),
        .is_user  (ctx_q.usr),
        .fault    (chk_fault),
        .need_wb  (chk_need_wb)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.st    = ST_READ;
                    ctx_d.vaddr = req_vaddr;
                    ctx_d.wr    = req_write;
                    ctx_d.usr   = req_user;
                    ctx_d.base  = pt_base;
                    ctx_d.paddr = '0;
                    ctx_d.fault = FLT_NONE;
                end
            end
            ST_READ: begin
                if (mem_req_ready) ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    ctx_d.fault = chk_fault;
                    if (chk_fault != FLT_NONE) begin
                        ctx_d.paddr = '0;
                        ctx_d.st    = ST_RESP;
                    end else begin
                        ctx_d.paddr = xlat_paddr;
                        if (chk_need_wb) begin
                            ctx_d.pte             = mem_rsp_rdata;
                            ctx_d.pte[FLAG_DIRTY] = 1'b1;
                            ctx_d.st              = ST_WBACK;
                        end else begin
                            ctx_d.st = ST_RESP;
                        end
                    end
                end
            end
            ST_WBACK: begin
                if (mem_req_ready) ctx_d.st = ST_RESP;
            end
            ST_RESP: begin
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, fault: FLT_NONE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        req_ready     = (ctx_q.st == ST_IDLE);
        mem_req_valid = (ctx_q.st == ST_READ) || (ctx_q.st == ST_WBACK);
        mem_req_write = (ctx_q.st == ST_WBACK);
        mem_req_addr  = entry_addr;
        mem_req_wdata = ctx_q.pte;
        rsp_valid     = (ctx_q.st == ST_RESP);
        rsp_paddr     = ctx_q.paddr;
        rsp_fault     = ctx_q.fault;
    end

    AST_RSP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0)); // R2

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[PAGE_BITS-1:0] == ctx_q.vaddr[PAGE_BITS-1:0])); // R3

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready); // R7

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
                                              && $stable(mem_req_write) && $stable(mem_req_wdata))); // R9

    AST_WB_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[FLAG_DIRTY] && mem_req_wdata[FLAG_PRESENT])); // R6

    AST_WB_BEFORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && !mem_req_ready) |=> !rsp_valid); // R6

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;

    typedef struct packed {
        logic [21:0] vpn;
        logic [9:0]  off;
        logic        wr;
        logic        usr;
        logic [31:0] pte;
        logic [1:0]  efault;
        logic        ewb;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{22'd5,       10'h3A5, 1'b0, 1'b0, 32'h0000_1231, 2'd0, 1'b0}, // R3 kernel load
        '{22'd6,       10'h010, 1'b1, 1'b0, 32'h0000_2AB3, 2'd0, 1'b1}, // R6 clean store
        '{22'd7,       10'h200, 1'b1, 1'b1, 32'h0000_00FF, 2'd0, 1'b0}, // R6 already dirty
        '{22'd8,       10'h044, 1'b0, 1'b1, 32'h0000_0550, 2'd1, 1'b0}, // R2 absent
        '{22'd9,       10'h3FF, 1'b1, 1'b0, 32'h0000_0771, 2'd2, 1'b0}, // R4 read-only
        '{22'd10,      10'h001, 1'b0, 1'b1, 32'h0000_0883, 2'd3, 1'b0}, // R5 kernel page
        '{22'd11,      10'h002, 1'b1, 1'b1, 32'h0000_0991, 2'd3, 1'b0}, // R5 priority over R4
        '{22'd12,      10'h003, 1'b1, 1'b1, 32'h0000_0AA6, 2'd1, 1'b0}, // R2 precedence
        '{22'h3F_FFFF, 10'h3FF, 1'b0, 1'b1, 32'h03FF_FFF5, 2'd0, 1'b0}, // R3 top page
        '{22'd1,       10'h001, 1'b1, 1'b1, 32'h0000_0007, 2'd0, 1'b1}, // R6 frame zero
        '{22'd13,      10'h155, 1'b0, 1'b0, 32'h0000_0BB5, 2'd0, 1'b0}  // R5 kernel on user page
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pt_base = 32'h0000_1000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    // Memory model: one response per read, one cycle after the handshake
    logic [31:0] mem_model [logic [31:0]];
    int          rd_count = 0;
    int          wr_count = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic        stall_mode = 1'b0;
    logic        ready_q = 1'b1;
    assign mem_req_ready = ready_q;

    always @(negedge clk) ready_q <= stall_mode ? ~ready_q : 1'b1;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem_model[mem_req_addr] = mem_req_wdata;
                wr_count     <= wr_count + 1;
                last_wr_addr <= mem_req_addr;
                last_wr_data <= mem_req_wdata;
            end else begin
                rd_count      <= rd_count + 1;
                last_rd_addr  <= mem_req_addr;
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem_model.exists(mem_req_addr) ? mem_model[mem_req_addr] : 32'h0;
            end
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cycles = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [31:0] got_paddr;
    logic [1:0]  got_fault;
    bit          ready_seen_busy;
    bit          got_rsp;

    task automatic translate(input logic [31:0] va, input logic wr, input logic usr, input bit hold_valid);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        if (!hold_valid) req_valid = 1'b0;
        ready_seen_busy = 1'b0;
        got_rsp = 1'b0;
        for (int i = 0; i < 60 && !got_rsp; i++) begin
            if (rsp_valid) begin
                got_rsp = 1'b1;
                got_paddr = rsp_paddr;
                got_fault = rsp_fault;
            end else begin
                if (req_ready) ready_seen_busy = 1'b1;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk("R8", "response seen", 32'(got_rsp), 32'd1);
        @(negedge clk);
        chk("R8", "rsp_valid one cycle", 32'(rsp_valid), 32'd0);
        chk("R7", "req_ready low while busy", 32'(ready_seen_busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "req_ready after reset", 32'(req_ready), 32'd1);
        chk("R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R10", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] ea, exp_pa;
            int rd0, wr0;
            ea = pt_base + {8'h0, VECS[v].vpn, 2'b00};
            mem_model[ea] = VECS[v].pte;
            exp_pa = (VECS[v].efault == 2'd0) ? {VECS[v].pte[25:4], VECS[v].off} : 32'h0;
            rd0 = rd_count; wr0 = wr_count;
            translate({VECS[v].vpn, VECS[v].off}, VECS[v].wr, VECS[v].usr, 1'b0);
            chk("R1", "single read", 32'(rd_count - rd0), 32'd1);
            chk("R1", "entry address", last_rd_addr, ea);
            chk("R2 R4 R5", "fault code", 32'(got_fault), 32'(VECS[v].efault));
            chk("R2 R3", "physical address", got_paddr, exp_pa);
            chk("R6", "write-back count", 32'(wr_count - wr0), 32'(VECS[v].ewb));
            chk("R6", "entry after access", mem_model[ea], VECS[v].ewb ? (VECS[v].pte | 32'h8) : VECS[v].pte);
            if (VECS[v].ewb) chk("R6", "write-back address", last_wr_addr, ea);
        end

        // R7: req_valid held high through a whole walk starts only one walk
        begin
            int rd0;
            mem_model[32'h0000_1000 + 32'd20 * 4] = 32'h0000_0C35;
            rd0 = rd_count;
            translate({22'd20, 10'h0AB}, 1'b0, 1'b1, 1'b1);
            repeat (3) @(negedge clk);
            chk("R7", "reads with valid held", 32'(rd_count - rd0), 32'd1);
            chk("R7", "held result", got_paddr, {22'h0C3, 10'h0AB});
        end

        // R9: stalled memory acknowledgement, with write-back
        begin
            int wr0;
            stall_mode = 1'b1;
            mem_model[32'h0000_1000 + 32'd30 * 4] = 32'h0000_0DD7;
            wr0 = wr_count;
            translate({22'd30, 10'h2C1}, 1'b1, 1'b1, 1'b0);
            chk("R9", "stalled result", got_paddr, {22'h0DD, 10'h2C1});
            chk("R9", "stalled fault", 32'(got_fault), 32'd0);
            chk("R9", "stalled write-back", 32'(wr_count - wr0), 32'd1);
            chk("R9", "stalled entry", mem_model[32'h0000_1000 + 32'd30 * 4], 32'h0000_0DDF);
            stall_mode = 1'b0;
        end

        // R1: a new table base is picked up at acceptance
        begin
            pt_base = 32'h0004_0000;
            mem_model[32'h0004_0000 + 32'd5 * 4] = 32'h0000_4445;
            translate({22'd5, 10'h111}, 1'b0, 1'b1, 1'b0);
            chk("R1", "new base address", last_rd_addr, 32'h0004_0014);
            chk("R1", "new base result", got_paddr, {22'h444, 10'h111});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule